// File: doc/BRIEF.md
# Serial Result Output Interface for a Sampling Converter

This block sits between a successive-approximation converter model and the pins of a converter device. It times each conversion, keeps the last finished result, and sends that result out one bit at a time, most significant bit first. The conversion itself is not modelled here: a parameterised busy window stands in for it, and the sample word is taken in when that window closes.

There are two clocking modes, chosen by a mode input. In internal mode the block makes its own burst of data clock pulses each time a conversion starts, and sends the result of the conversion before that one. In external mode the data clock comes from outside and passes through a two-flop synchronizer. The read is then started by a control edge, not by the conversion. A sync pulse marks the first clock, and after the result the data line carries a tag input delayed by sixteen clocks, so several devices can be read in a daisy chain. A format input selects straight (offset) binary, or two's complement by flipping the top bit.

Top module: `sar_result_serializer`

## Requirements
- R1: While reset is asserted, serOut, dclkOut, syncOut, busy and convStart are all low.
- R2: The chip-select and read/convert inputs are ORed. A high-to-low change of that OR is a conversion request. An accepted request gives a single-cycle convStart pulse, and busy then stays high for exactly CONV_CYCLES clocks (CLK_HZ × CONV_NS / 1e9, which is 384 at the defaults). No other input change starts a conversion.
- R3: A conversion request that arrives while busy is high is ignored: no convStart, no change to the busy window, and no extra data clock pulses.
- R4: The sample word is captured when busy ends. The format is applied when a transmission is loaded. With binFmt high the word is sent unchanged. With binFmt low bit 15 is inverted and the other bits are unchanged.
- R5: In internal mode, each accepted conversion produces exactly 16 pulses on dclkOut, each DCLK_HALF clocks high and DCLK_HALF clocks low. The word goes out MSB first, and each bit is stable across the falling edge of its pulse. After the burst dclkOut stays low.
- R6: The word sent in internal mode is the result of the conversion before the one just started. After reset that result is 0x0000.
- R7: In internal mode, outside a burst, serOut holds the tagIn level sampled when the last conversion was accepted. Later changes of tagIn have no effect on it.
- R8: In external mode, a read starts on a rising read/convert with chip select low, or on a falling chip select with read/convert high. Neither event starts a conversion. syncOut rises at the first rising edge of extDclk after the read starts and falls at the second.
- R9: In external mode, word bit (16−k) is on serOut after rising edge k, for k = 1 to 16. After edge k ≥ 17, serOut shows the tagIn level sampled at edge k−16.
- R10: In external mode, dclkOut stays low, including through a conversion.
- R11: In external mode, raising chip select or lowering read/convert stops the read. serOut then holds its level through later extDclk edges, and syncOut stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampleWord | input | 16 | Offset-binary result from the converter model |
| csN | input | 1 | Chip select, active low |
| rdCnv | input | 1 | Read/convert control; falling edge requests a conversion |
| extMode | input | 1 | 1 = external data clock, 0 = internal burst |
| binFmt | input | 1 | 1 = straight binary, 0 = two's complement |
| tagIn | input | 1 | Tag bit for idle level and daisy chaining |
| extDclk | input | 1 | External data clock, asynchronous |
| dclkOut | output | 1 | Data clock burst driven in internal mode |
| serOut | output | 1 | Serial data line |
| syncOut | output | 1 | Frame marker in external mode |
| convStart | output | 1 | One-cycle conversion start strobe |
| busy | output | 1 | High while a conversion is timing |

## Verification
The bench sweeps consecutive conversions over corner words (all zeros, all ones, each side of mid-scale) in both formats. A design that sent the current sample instead of the previous one, or that flipped the wrong bit, shows the wrong word on the falling edges. A start request placed inside the busy window catches a design that restarts the timer or adds a second burst. The external read is checked edge by edge, so a tag delay off by one, a sync pulse on the wrong edge, or shifting that continues after chip select rises all give wrong bits. Both read triggers are used, and the bench checks that neither one starts a conversion.

// File: rtl/serout_pkg.sv
package serout_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic convDone;  // capture sample word
    logic load;      // load formatted result into the shifter
    logic shift;     // advance the shifter by one bit
    logic tagCap;    // latch idle tag level
    logic txActive;  // internal burst in progress
    logic syncSet;
    logic syncClr;
    logic edgeTick;  // external clock rising edge while reading
  } ctl_t;
endpackage

// File: rtl/serout_ctrl.sv
module serout_ctrl
  import serout_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int CONV_CYCLES = 384,
  parameter int DCLK_HALF   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csN,
  input  logic rdCnv,
  input  logic extMode,
  input  logic extDclk,
  output ctl_t ctl,
  output logic convStart,
  output logic busy,
  output logic dclkOut
);
  localparam int CW  = $clog2(CONV_CYCLES + 1);
  localparam int DW  = $clog2(DCLK_HALF + 1);
  localparam int PCW = $clog2(WORD_W + 1);

  // control edge decode
  logic prevCs, prevRd;
  logic selNow, selPrev, convTrig, startOk, startTx;
  assign selNow   = csN | rdCnv;
  assign selPrev  = prevCs | prevRd;
  assign convTrig = selPrev & ~selNow;

  // conversion timer
  logic          busyR;
  logic [CW-1:0] convCnt;
  assign startOk = convTrig & ~busyR;
  assign startTx = startOk & ~extMode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevCs    <= 1'b1;
      prevRd    <= 1'b1;
      convStart <= 1'b0;
      busyR     <= 1'b0;
      convCnt   <= '0;
    end else begin
      prevCs    <= csN;
      prevRd    <= rdCnv;
      convStart <= startOk;
      if (startOk) begin
        busyR   <= 1'b1;
        convCnt <= CW'(CONV_CYCLES - 1);
      end else if (busyR) begin
        if (convCnt == '0) busyR <= 1'b0;
        else               convCnt <= convCnt - 1'b1;
      end
    end
  end
  assign busy = busyR;

  // internal data clock burst
  logic           txActive, dclkR;
  logic [DW-1:0]  divCnt;
  logic [PCW-1:0] pulseCnt;
  logic           divWrap, shiftInt;
  assign divWrap  = txActive && (divCnt == DW'(DCLK_HALF - 1));
  assign shiftInt = divWrap && !dclkR && (pulseCnt != '0) && (pulseCnt != PCW'(WORD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txActive <= 1'b0;
      dclkR    <= 1'b0;
      divCnt   <= '0;
      pulseCnt <= '0;
    end else if (extMode) begin
      txActive <= 1'b0;
      dclkR    <= 1'b0;
    end else if (startTx) begin
      txActive <= 1'b1;
      dclkR    <= 1'b0;
      divCnt   <= '0;
      pulseCnt <= '0;
    end else if (txActive) begin
      if (divWrap) begin
        divCnt <= '0;
        if (dclkR) begin
          dclkR <= 1'b0;
        end else if (pulseCnt == PCW'(WORD_W)) begin
          txActive <= 1'b0;
        end else begin
          dclkR    <= 1'b1;
          pulseCnt <= pulseCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end
  assign dclkOut = dclkR;

  // external clock: two-flop synchronizer plus edge detect
  logic syncA, syncB, syncC, extRise;
  logic extTrig, readEn, extArmed, firstEdge;
  assign extRise = syncB & ~syncC;
  assign readEn  = ~csN & rdCnv;
  assign extTrig = extMode & ((~prevRd & rdCnv & ~csN) | (prevCs & ~csN & rdCnv));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA     <= 1'b0;
      syncB     <= 1'b0;
      syncC     <= 1'b0;
      extArmed  <= 1'b0;
      firstEdge <= 1'b0;
    end else begin
      syncA <= extDclk;
      syncB <= syncA;
      syncC <= syncB;
      if (!extMode || !readEn) begin
        extArmed <= 1'b0;
      end else if (extTrig) begin
        extArmed  <= 1'b1;
        firstEdge <= 1'b1;
      end else if (extArmed && extRise) begin
        firstEdge <= 1'b0;
      end
    end
  end

  logic extTick;
  assign extTick = extArmed & extRise;

  always_comb begin
    ctl          = '0;
    ctl.convDone = busyR && (convCnt == '0);
    ctl.load     = startTx | extTrig;
    ctl.shift    = shiftInt | (extTick & ~firstEdge);
    ctl.tagCap   = startTx;
    ctl.txActive = txActive;
    ctl.syncSet  = extTick & firstEdge;
    ctl.syncClr  = ~extArmed | (extTick & ~firstEdge);
    ctl.edgeTick = extTick;
  end
endmodule

// File: rtl/serout_datapath.sv
module serout_datapath
  import serout_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [WORD_W-1:0] sampleWord,
  input  logic              binFmt,
  input  logic              tagIn,
  input  logic              extMode,
  output logic              serOut,
  output logic              syncOut
);
  logic [WORD_W-1:0] resultReg, shreg, fmtWord;
  logic              tagHold, tagPipe, syncR;

  // two's complement from offset binary: flip the sign bit
  assign fmtWord = binFmt ? resultReg : {~resultReg[WORD_W-1], resultReg[WORD_W-2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resultReg <= '0;
      shreg     <= '0;
      tagHold   <= 1'b0;
      tagPipe   <= 1'b0;
      syncR     <= 1'b0;
    end else begin
      if (ctl.convDone) resultReg <= sampleWord;
      if (ctl.load)       shreg <= fmtWord;
      else if (ctl.shift) shreg <= {shreg[WORD_W-2:0], tagPipe};
      if (ctl.edgeTick) tagPipe <= tagIn;
      if (ctl.tagCap)   tagHold <= tagIn;
      if (ctl.syncSet)      syncR <= 1'b1;
      else if (ctl.syncClr) syncR <= 1'b0;
    end
  end

  assign serOut  = (extMode | ctl.txActive) ? shreg[WORD_W-1] : tagHold;
  assign syncOut = syncR;
endmodule

// File: rtl/sar_result_serializer.sv
module sar_result_serializer
  import serout_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CLK_HZ    = 50_000_000,
  parameter int CONV_NS   = 7680,
  parameter int DCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] sampleWord,
  input  logic              csN,
  input  logic              rdCnv,
  input  logic              extMode,
  input  logic              binFmt,
  input  logic              tagIn,
  input  logic              extDclk,
  output logic              dclkOut,
  output logic              serOut,
  output logic              syncOut,
  output logic              convStart,
  output logic              busy
);
  localparam longint CONV_CYC_L  = (longint'(CLK_HZ) * longint'(CONV_NS)) / 64'd1000000000;
  localparam int     CONV_CYCLES = int'(CONV_CYC_L);

  ctl_t ctl;

  serout_ctrl #(
    .WORD_W(WORD_W), .CONV_CYCLES(CONV_CYCLES), .DCLK_HALF(DCLK_HALF)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rdCnv(rdCnv), .extMode(extMode),
    .extDclk(extDclk), .ctl(ctl), .convStart(convStart), .busy(busy),
    .dclkOut(dclkOut)
  );

  serout_datapath #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .sampleWord(sampleWord),
    .binFmt(binFmt), .tagIn(tagIn), .extMode(extMode), .serOut(serOut),
    .syncOut(syncOut)
  );
endmodule

// File: rtl/serializer_checker.sv
module serializer_checker (
  input logic clk,
  input logic rst_n,
  input logic extMode,
  input logic convStart,
  input logic busy,
  input logic dclkOut,
  input logic serOut,
  input logic syncOut
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (!serOut && !dclkOut && !syncOut && !busy && !convStart);
    end
  end

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    convStart |=> !convStart);
  a_r2_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    convStart |-> busy);
  a_r3_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    convStart |-> !$past(busy));
  a_r5_burst_inside_conv: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclkOut) |-> busy);
  a_r10_ext_dclk_low: assert property (@(posedge clk) disable iff (!rst_n)
    extMode |=> !dclkOut);
  a_r8_sync_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(syncOut) |-> $past(extMode));
endmodule

bind sar_result_serializer serializer_checker chk_i (
  .clk(clk), .rst_n(rst_n), .extMode(extMode), .convStart(convStart),
  .busy(busy), .dclkOut(dclkOut), .serOut(serOut), .syncOut(syncOut)
);

// File: tb/sar_result_serializer_tb_top.sv
module sar_result_serializer_tb_top;
  localparam int CONV = (50_000_000 / 1000) * 7680 / 1_000_000;

  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] sampleWord;
  logic csN, rdCnv, extMode, binFmt, tagIn, extDclk;
  logic dclkOut, serOut, syncOut, convStart, busy;

  int checkCount = 0;
  int failCount  = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sar_result_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .sampleWord(sampleWord), .csN(csN),
    .rdCnv(rdCnv), .extMode(extMode), .binFmt(binFmt), .tagIn(tagIn),
    .extDclk(extDclk), .dclkOut(dclkOut), .serOut(serOut),
    .syncOut(syncOut), .convStart(convStart), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fmtOf(input logic [15:0] w, input logic f);
    return f ? w : (w ^ 16'h8000);
  endfunction

  function automatic logic [15:0] sampleFor(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h7FFF;
      default: return 16'(i * 16'h2F1B + 16'h0137);
    endcase
  endfunction

  function automatic logic tagFor(input int e);
    return (e % 3) == 1;
  endfunction

  task automatic runInternal(input logic [15:0] smp, input logic fmt, input logic tg,
                             input logic inject, input logic [15:0] expW);
    logic [15:0] got;
    int rises, busyN, extra;
    logic prevD;
    sampleWord = smp; binFmt = fmt; tagIn = tg;
    @(negedge clk); csN = 1'b0; rdCnv = 1'b0;
    @(negedge clk); rdCnv = 1'b1;
    chk(convStart == 1'b1, "R2 convStart strobe", int'(convStart), 1);
    chk(busy == 1'b1, "R2 busy raised", int'(busy), 1);
    got = '0; rises = 0; busyN = 0; extra = 0; prevD = dclkOut;
    for (int k = 0; k < 1000 && busy; k++) begin
      busyN++;
      if (k > 0 && convStart) extra++;
      if (dclkOut && !prevD) rises++;
      if (!dclkOut && prevD) got = {got[14:0], serOut};
      prevD = dclkOut;
      if (inject && k == 20) rdCnv = 1'b0;
      if (inject && k == 21) rdCnv = 1'b1;
      if (k == 150) tagIn = ~tg;
      @(negedge clk);
    end
    chk(busyN == CONV, "R2 busy length", busyN, CONV);
    chk(extra == 0, "R3 no restart while busy", extra, 0);
    chk(rises == 16, "R5 sixteen pulses", rises, 16);
    chk(got == expW, "R6 R4 previous word sent", int'(got), int'(expW));
    chk(dclkOut == 1'b0, "R5 dclk low after burst", int'(dclkOut), 0);
    chk(serOut == tg, "R7 idle tag held", int'(serOut), int'(tg));
  endtask

  task automatic extEdge(input int e, output logic so, output logic sy);
    @(negedge clk); extDclk = 1'b1;
    repeat (5) @(negedge clk);
    so = serOut; sy = syncOut;
    extDclk = 1'b0; tagIn = tagFor(e + 1);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCount++; failCount++;
      $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    logic [15:0] prevRaw, s1;
    logic so, sy, held;
    int starts, dclkHigh;
    rst_n = 1'b0; csN = 1'b1; rdCnv = 1'b1; extMode = 1'b0; binFmt = 1'b1;
    tagIn = 1'b0; extDclk = 1'b0; sampleWord = '0;
    repeat (3) @(negedge clk);
    chk(!serOut && !dclkOut && !syncOut && !busy && !convStart, "R1 reset idle",
        int'({serOut, dclkOut, syncOut, busy, convStart}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // internal mode sweep
    prevRaw = 16'h0000;
    for (int i = 0; i < 10; i++) begin
      logic f;
      f = (i % 4 == 1 || i % 4 == 2);
      runInternal(sampleFor(i), f, 1'(i[1] ^ i[0]), i == 2, fmtOf(prevRaw, f));
      prevRaw = sampleFor(i);
      repeat (4) @(negedge clk);
    end

    // external mode: a conversion gives no clock (R10)
    extMode = 1'b1; s1 = 16'hC35A; sampleWord = s1; binFmt = 1'b0;
    repeat (2) @(negedge clk);
    csN = 1'b0; rdCnv = 1'b0;
    @(negedge clk);
    chk(convStart == 1'b1, "R2 ext-mode conversion start", int'(convStart), 1);
    dclkHigh = 0;
    for (int k = 0; k < 1000 && busy; k++) begin
      if (dclkOut) dclkHigh++;
      @(negedge clk);
    end
    chk(dclkHigh == 0, "R10 no dclk in external mode", dclkHigh, 0);

    // trigger by rising read/convert with select low (R8)
    tagIn = tagFor(1);
    starts = 0;
    rdCnv = 1'b1;
    repeat (3) begin
      @(negedge clk);
      if (convStart) starts++;
    end
    chk(syncOut == 1'b0, "R8 sync low before first edge", int'(syncOut), 0);
    for (int e = 1; e <= 24; e++) begin
      extEdge(e, so, sy);
      if (convStart) starts++;
      if (e == 1) chk(sy == 1'b1, "R8 sync on first edge", int'(sy), 1);
      if (e == 2) chk(sy == 1'b0, "R8 sync ends at second edge", int'(sy), 0);
      if (e <= 16) begin
        logic [15:0] w;
        w = fmtOf(s1, 1'b0);
        chk(so == w[16 - e], "R9 R4 ext data bit", int'(so), int'(w[16 - e]));
      end else begin
        chk(so == tagFor(e - 16), "R9 tag delayed 16", int'(so), int'(tagFor(e - 16)));
      end
    end
    chk(starts == 0, "R8 read does not convert", starts, 0);

    // stop by raising select (R11)
    @(negedge clk); csN = 1'b1;
    @(negedge clk);
    held = serOut;
    for (int e = 25; e <= 27; e++) begin
      extEdge(e, so, sy);
      chk(so == held && sy == 1'b0, "R11 hold after stop", int'({so, sy}), int'({held, 1'b0}));
    end

    // trigger by falling select with read/convert high (R8)
    binFmt = 1'b1; starts = 0;
    @(negedge clk); csN = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (convStart) starts++;
    end
    for (int e = 1; e <= 16; e++) begin
      extEdge(e, so, sy);
      if (convStart) starts++;
      if (e == 1) chk(sy == 1'b1, "R8 select-edge sync", int'(sy), 1);
      chk(so == s1[16 - e], "R9 R4 straight binary bit", int'(so), int'(s1[16 - e]));
    end
    chk(starts == 0, "R8 select edge does not convert", starts, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule